// File: doc/BRIEF.md
# Grouped Interrupt Combiner with Masking

This block merges a wide bank of level-sensitive interrupt sources into a smaller set of group interrupt lines. Sources are banked eight to a group. Each group has an 8-bit enable mask and an 8-bit pending vector. The group's output line is high whenever any source that is both pending and enabled is high. The pending vector follows the input levels. A small 32-bit register bus sets and clears mask bits, and reads back the masks, the raw pending bits, the masked pending bits and a summary of all group lines.

Registers are packed one byte per group and four groups per 32-bit word. Every 16-byte block of the address space serves four consecutive groups. Summary words follow the last such block. Software enables sources with write-ones-to-set and write-ones-to-clear words, so no read-modify-write is needed. An optional limited configuration lets only the lower groups take input. The group count is a parameter, with a default of 64 groups and 512 sources.

Top module: `irq_combiner`

## Requirements
- R1: Source index n belongs to group n >> 3 and drives bit n & 7 of that group's pending and mask bytes.
- R2: Each pending bit equals the level of its source, sampled on every clock edge. Word 2 of a block (byte offset 8) reads the raw pending bytes.
- R3: Output irq_o[g] is registered. It is high exactly when mask[g] & pending[g] is non-zero, and it changes on the clock edge that samples the causing input change or mask write.
- R4: Block q (offset >> 4) serves groups 4q to 4q+3. Group 4q+k occupies bits 8k+7:8k of every word in the block.
- R5: A write to word 0 of a block (byte offset 0) ORs the written ones into the four masks and does not raise err_o.
- R6: A write to word 1 of a block (byte offset 4) clears the mask bits where ones are written.
- R7: Word 3 of a block (byte offset 12) reads pending ANDed with mask.
- R8: Summary word s sits at byte offset 16*(NUM_GROUPS/4) + 4s. Its bit b is irq_o[32s+b], and bits with no group read 0.
- R9: A write to any other address, including status words, summary words, unmapped and misaligned addresses, changes no state. Such a write raises err_o for exactly one cycle, in the cycle after the write.
- R10: With EXT_MODE set, groups at or above EXT_GROUPS ignore their inputs: their pending bits stay 0 and their outputs never assert.
- R11: Asynchronous reset clears every mask, every pending bit, every output and err_o.
- R12: Reads of word 0 or word 1 of a block return the current masks of its four groups.
- R13: Read data is registered. rdata_o shows the selected word one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle strobe for an illegal write |
| irq_o | output | NUM_GROUPS | Group interrupt lines |

## Verification
A table walks a single group through combinations of pending and mask bytes: all-pending with no mask, mask with nothing pending, matching and disjoint single bits, and partial overlaps. This separates a real AND-then-OR from an OR of either operand, and from lane or bit misplacement in the raw, masked and mask read words. A single high source at index 300 checks the index-to-group mapping, the lane choice inside a block and the upper summary word. Separate patterns check the OR and clear semantics of the mask words, illegal writes that carry all-ones data, and reset taken while an output is asserted. A second instance in the limited configuration, driven with every source high, shows that the cut-off at the group limit lands on the right group.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    W_EN_SET = 2'd0,
    W_EN_CLR = 2'd1,
    W_RAW    = 2'd2,
    W_MSK    = 2'd3
  } quad_word_e;
endpackage

// File: rtl/irq_comb_group.sv
module irq_comb_group
  import irq_comb_pkg::*;
#(
  parameter bit ACCEPT = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  lane_t src_i,
  input  lane_t set_i,
  input  lane_t clr_i,
  output lane_t mask_o,
  output lane_t pend_o,
  output logic  irq_o
);
  lane_t mask_q, mask_d;
  lane_t pend_q, pend_d;
  logic  irq_q;

  assign mask_d = (mask_q | set_i) & ~clr_i;

  generate
    if (ACCEPT) begin : g_take
      assign pend_d = src_i;
    end else begin : g_hold
      // inputs ignored; pending stays at its reset value
      assign pend_d = pend_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |(mask_d & pend_d);
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_comb_regif.sv
module irq_comb_regif
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  lane_t                 mask_i [NUM_GROUPS],
  input  lane_t                 pend_i [NUM_GROUPS],
  input  logic [NUM_GROUPS-1:0] irq_i,
  output lane_t                 set_o  [NUM_GROUPS],
  output lane_t                 clr_o  [NUM_GROUPS],
  output logic [WORD_W-1:0]     rdata_o,
  output logic                  err_o
);
  localparam int unsigned NQ     = NUM_GROUPS / LANES;
  localparam int unsigned NSUM   = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned SUM_LO = NQ * 4;

  logic [WIDX_W-1:0] word_idx;
  int unsigned       widx, quad, sum_idx;
  quad_word_e        sel;
  logic              aligned, in_quad, in_sum, wr_ok;
  logic [NSUM*WORD_W-1:0] irq_pad;
  logic [WORD_W-1:0] rd_val;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign widx     = 32'(word_idx);
  assign quad     = widx >> 2;
  assign sum_idx  = widx - SUM_LO;
  assign sel      = quad_word_e'(word_idx[1:0]);
  assign in_quad  = aligned && (widx < SUM_LO);
  assign in_sum   = aligned && (widx >= SUM_LO) && (widx < SUM_LO + NSUM);
  assign wr_ok    = req_i && we_i && in_quad && (sel == W_EN_SET || sel == W_EN_CLR);

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_strobe
      localparam int unsigned Q = g / LANES;
      localparam int unsigned L = g % LANES;
      assign set_o[g] = (wr_ok && sel == W_EN_SET && quad == Q) ?
                        wdata_i[L*LANE_W +: LANE_W] : '0;
      assign clr_o[g] = (wr_ok && sel == W_EN_CLR && quad == Q) ?
                        wdata_i[L*LANE_W +: LANE_W] : '0;
    end
  endgenerate

  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_GROUPS-1:0] = irq_i;
  end

  always_comb begin
    rd_val = '0;
    for (int unsigned k = 0; k < NUM_GROUPS; k++) begin
      if (in_quad && (k / LANES) == quad) begin
        unique case (sel)
          W_EN_SET, W_EN_CLR: rd_val[(k%LANES)*LANE_W +: LANE_W] = mask_i[k];
          W_RAW:              rd_val[(k%LANES)*LANE_W +: LANE_W] = pend_i[k];
          W_MSK:              rd_val[(k%LANES)*LANE_W +: LANE_W] = pend_i[k] & mask_i[k];
          default:            ;
        endcase
      end
    end
    for (int unsigned s = 0; s < NSUM; s++) begin
      if (in_sum && s == sum_idx) rd_val = irq_pad[s*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (req_i && !we_i) rdata_q <= rd_val;
      err_q <= req_i && we_i && !wr_ok;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_comb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12,
  parameter bit          EXT_MODE   = 1'b0,
  parameter int unsigned EXT_GROUPS = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_GROUPS*LANE_W-1:0] src_i,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic                         err_o,
  output logic [NUM_GROUPS-1:0]        irq_o
);
  lane_t mask [NUM_GROUPS];
  lane_t pend [NUM_GROUPS];
  lane_t set_s[NUM_GROUPS];
  lane_t clr_s[NUM_GROUPS];

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam bit TAKE = !EXT_MODE || (g < EXT_GROUPS);
      irq_comb_group #(.ACCEPT(TAKE)) u_grp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i[g*LANE_W +: LANE_W]),
        .set_i  (set_s[g]),
        .clr_i  (clr_s[g]),
        .mask_o (mask[g]),
        .pend_o (pend[g]),
        .irq_o  (irq_o[g])
      );
    end
  endgenerate

  irq_comb_regif #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mask_i  (mask),
    .pend_i  (pend),
    .irq_i   (irq_o),
    .set_o   (set_s),
    .clr_o   (clr_s),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/irq_comb_chk.sv
module irq_comb_chk #(
  parameter int unsigned NUM_GROUPS = 64,
  parameter int unsigned ADDR_W     = 12,
  parameter bit          EXT_MODE   = 1'b0,
  parameter int unsigned EXT_GROUPS = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_GROUPS*8-1:0] src_i,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic [31:0]             rdata_o,
  input logic                    err_o,
  input logic [NUM_GROUPS-1:0]   irq_o
);
  localparam int unsigned NQ = NUM_GROUPS / 4;
  localparam logic [ADDR_W-1:0] CLR0_A = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SUM0_A = ADDR_W'(NQ * 16);
  localparam int unsigned SW = (NUM_GROUPS < 32) ? NUM_GROUPS : 32;

  assert_err_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && we_i));

  assert_enable_write_no_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[3:0] == 4'h0 && 32'(addr_i) < NQ * 16) |=> !err_o);

  assert_clear_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == CLR0_A && wdata_i[7:0] == 8'hFF) |=> !irq_o[0]);

  assert_summary_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == SUM0_A) |=> rdata_o[SW-1:0] == $past(irq_o[SW-1:0]));

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_idle
      assert_idle_group_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i[g*8 +: 8] == 8'h00) |=> !irq_o[g]);
    end
    if (EXT_MODE && EXT_GROUPS < NUM_GROUPS) begin : g_ext
      assert_ext_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|irq_o[NUM_GROUPS-1:EXT_GROUPS]));
    end
  endgenerate
endmodule

bind irq_combiner irq_comb_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .ADDR_W     (ADDR_W),
  .EXT_MODE   (EXT_MODE),
  .EXT_GROUPS (EXT_GROUPS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .irq_o   (irq_o)
);

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [511:0] src0 = '0;
  logic [63:0]  src1 = '0;
  logic        req0 = 1'b0, req1 = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        err0, err1;
  logic [63:0] irq0;
  logic [7:0]  irq1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_combiner u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src0), .req_i(req0), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0), .err_o(err0), .irq_o(irq0));

  irq_combiner #(.NUM_GROUPS(8), .EXT_MODE(1'b1), .EXT_GROUPS(5)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src1), .req_i(req1), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1), .err_o(err1), .irq_o(irq1));

  typedef struct packed {
    logic [7:0] pend;
    logic [7:0] mask;
    logic [7:0] msk;
    logic       irq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hFF, 8'h00, 8'h00, 1'b0},
    '{8'h00, 8'hFF, 8'h00, 1'b0},
    '{8'h01, 8'h01, 8'h01, 1'b1},
    '{8'h80, 8'h01, 8'h00, 1'b0},
    '{8'h80, 8'h80, 8'h80, 1'b1},
    '{8'hA5, 8'h5A, 8'h00, 1'b0},
    '{8'hA5, 8'hFF, 8'hA5, 1'b1},
    '{8'h3C, 8'h0F, 8'h0C, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit dev, input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    if (dev) req1 = 1'b1; else req0 = 1'b1;
    tick();
    req0 = 1'b0; req1 = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit dev, input logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    if (dev) req1 = 1'b1; else req0 = 1'b1;
    tick();
    req0 = 1'b0; req1 = 1'b0;
    d = dev ? rdata1 : rdata0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 irq after reset", irq0, 64'h0);
    chk("R11 err after reset", {63'h0, err0}, 64'h0);
    rst_n = 1'b1;
    tick();
    rd(0, 12'h000, d); chk("R11 mask after reset", d, 0);
    rd(0, 12'h100, d); chk("R11 summary after reset", d, 0);

    // R2 R3 R4 R7 R12: table walk on group 5 (block 1, lane 1)
    for (int i = 0; i < 8; i++) begin
      wr(0, 12'h014, 32'hFFFF_FFFF);
      wr(0, 12'h010, {16'h0, VECS[i].mask, 8'h00});
      src0[47:40] = VECS[i].pend;
      tick();
      chk($sformatf("R3 irq group5 vec%0d", i), {63'h0, irq0[5]}, {63'h0, VECS[i].irq});
      rd(0, 12'h01C, d); chk($sformatf("R7 masked vec%0d", i), d, {16'h0, VECS[i].msk, 8'h00});
      rd(0, 12'h018, d); chk($sformatf("R2 R4 raw vec%0d", i), d, {16'h0, VECS[i].pend, 8'h00});
      rd(0, 12'h010, d); chk($sformatf("R12 set-word read vec%0d", i), d, {16'h0, VECS[i].mask, 8'h00});
      rd(0, 12'h014, d); chk($sformatf("R12 clr-word read vec%0d", i), d, {16'h0, VECS[i].mask, 8'h00});
    end
    src0 = '0;
    wr(0, 12'h014, 32'hFFFF_FFFF);

    // R1 R8: source 300 -> group 37 bit 4 (block 9, lane 1)
    wr(0, 12'h090, 32'h0000_1000);
    src0[300] = 1'b1;
    chk("R3 irq not early", irq0, 64'h0);
    tick();
    chk("R1 R3 group37 asserted", irq0, 64'h1 << 37);
    rd(0, 12'h098, d); chk("R1 raw bit position", d, 32'h0000_1000);
    rd(0, 12'h104, d); chk("R8 summary upper word", d, 32'h0000_0020);
    rd(0, 12'h100, d); chk("R8 summary lower word", d, 32'h0);
    // R13: read data holds without a read
    src0[300] = 1'b0;
    tick();
    chk("R3 group37 released", irq0, 64'h0);
    chk("R13 rdata holds", rdata0, 32'h0);
    rd(0, 12'h104, d); chk("R13 R8 summary cleared", d, 32'h0);

    // R5 R6: OR and clear semantics on group 0
    wr(0, 12'h000, 32'h0000_0001);
    chk("R5 no err on set write", {63'h0, err0}, 64'h0);
    wr(0, 12'h000, 32'h0000_0002);
    rd(0, 12'h000, d); chk("R5 set ORs", d, 32'h0000_0003);
    wr(0, 12'h004, 32'h0000_0001);
    rd(0, 12'h000, d); chk("R6 clear bit0", d, 32'h0000_0002);
    src0[1] = 1'b1;
    tick();
    chk("R6 remaining bit drives irq", irq0, 64'h1);

    // R9: illegal writes ignored, one-cycle strobe
    wr(0, 12'h008, 32'hFFFF_FFFF);
    chk("R9 err on raw write", {63'h0, err0}, 64'h1);
    tick();
    chk("R9 err one cycle", {63'h0, err0}, 64'h0);
    wr(0, 12'h100, 32'hFFFF_FFFF);
    chk("R9 err on summary write", {63'h0, err0}, 64'h1);
    wr(0, 12'h001, 32'hFFFF_FFFF);
    chk("R9 err on misaligned write", {63'h0, err0}, 64'h1);
    wr(0, 12'h00C, 32'hFFFF_FFFF);
    rd(0, 12'h000, d); chk("R9 masks untouched", d, 32'h0000_0002);
    chk("R9 irq untouched", irq0, 64'h1);

    // R11: reset while asserted
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async clear irq", irq0, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R11 mask cleared keeps irq low", irq0, 64'h0);
    rd(0, 12'h000, d); chk("R11 mask read zero", d, 32'h0);
    src0 = '0;

    // R10: limited configuration, groups 5..7 ignore inputs
    wr(1, 12'h000, 32'hFFFF_FFFF);
    wr(1, 12'h010, 32'hFFFF_FFFF);
    src1 = '1;
    tick();
    chk("R10 only lower groups", {56'h0, irq1}, 64'h1F);
    rd(1, 12'h018, d); chk("R10 raw upper block", d, 32'h0000_00FF);
    rd(1, 12'h020, d); chk("R10 R8 summary small", d, 32'h0000_001F);

    summary();
  end
endmodule